// File: doc/BRIEF.md
# PLL Clock-Source Switch Sequencer

This controller sits beside a system clock PLL and owns the decision of which clock drives the core. After reset the core runs from the 12 MHz internal RC oscillator. The PLL is unpowered and its output is bypassed. Software writes a feedback multiplier and an output divider through a small register port, then issues commands on a command address. The commands power the PLL up, restart the settling wait, connect the core to the PLL, disconnect it, or power the PLL down.

Every action is gated by a five-state sequence: off, configured, settling, locked and connected. A settling counter runs on the reference clock. The block reaches the locked state only when the counter has covered the full settling interval and the lock input is high. The interval defaults to 1200 reference cycles, which is 100 µs at 12 MHz. Moving the core between the RC clock and the PLL clock goes through a break-before-make pair of gate enables, so the two clocks are never enabled together. If lock is lost, the block drops back to the RC clock and to settling without any software action.

Top module: `pll_switch_seq`

## Requirements
- R1: After reset the outputs are as follows. `state_o` is 0 (off), and the state codes are 0 off, 1 configured, 2 settling, 3 locked and 4 connected. `pll_pwr` is 0, `sel_rc` is 1 and `sel_pll` is 0. `fb_mult` is 1, `div_code` is 0, and both error flags are 0.
- R2: A write to address 0 is a multiplier write. It is accepted only when the data is 1 to 32 and the state is off or configured. An accepted write loads `fb_mult` and moves the off state to configured. A rejected write leaves `fb_mult` unchanged and sets the sticky `err_cfg`.
- R3: A write to address 1 is a divider write. It accepts only data 2, 4, 8 or 16, stored as `div_code` 0, 1, 2 or 3 (divide by 2 to the power code+1). Any other value is rejected, leaves `div_code` unchanged and sets `err_cfg`.
- R4: A write to address 2 with data bits [2:0] = 001 is the activate command. In the configured, settling or locked state it enters settling, sets `pll_pwr` and restarts the settling count from zero. In the off or connected state it is ignored and sets the sticky `err_seq`.
- R5: The settling state moves to locked only on the SETTLE_CYC-th cycle after the last restart, and only when `pll_lock` is high. If lock is low, the block stays in settling.
- R6: The connect command (bits [2:0] = 010) moves the locked state to connected when lock is high. In any other state it is ignored and sets `err_seq`.
- R7: Entering the connected state lowers `sel_rc` two cycles later and raises `sel_pll` four cycles later. `sel_rc` and `sel_pll` are never high together.
- R8: Lock going low in the locked or connected state moves the block to settling and restarts the count. From the connected state, `sel_pll` falls within 2 cycles and `sel_rc` returns within 4 cycles.
- R9: The stop command (bits [2:0] = 100) has a different effect in each state. In the connected state it returns to locked and the core goes back to the RC clock. In the settling or locked state it returns to configured and clears `pll_pwr`. In the off or configured state it sets `err_seq`.
- R10: A command write with more than one of bits [2:0] set changes no state and sets `err_seq`. Bit 3 of a command write clears both error flags. A clear and an error raised in the same write leave the error flag set.
- R11: Multiplier or divider writes in the settling, locked or connected state are rejected with `err_cfg`. A write to address 3 also sets `err_cfg`.
- R12: When lock loss and a connect command fall in the same cycle in the locked state, the lock loss wins. The state becomes settling and `err_seq` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (RC) clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 multiplier, 1 divider, 2 command, 3 unused |
| wr_data | input | 8 | Write data |
| pll_lock | input | 1 | Lock indication from the PLL |
| pll_pwr | output | 1 | PLL power enable |
| fb_mult | output | 6 | Feedback multiplier value |
| div_code | output | 2 | Output divider code |
| state_o | output | 3 | Sequencer state code |
| err_cfg | output | 1 | Sticky rejected-configuration flag |
| err_seq | output | 1 | Sticky rejected-command flag |
| sel_rc | output | 1 | Gate enable for the RC clock |
| sel_pll | output | 1 | Gate enable for the divided PLL clock |

## Verification
A loss of lock and a connect request can land on the same reference edge while the block is locked. The bench provokes this by lowering `pll_lock` in the same cycle that it drives the connect write. It then expects settling, a set `err_seq` and no rise of `sel_pll`. A similar collision arises when a second activate lands partway through settling. The bench judges that case by showing that locked is reached a full interval after the second write, not after the first.

// File: rtl/pll_switch_seq.sv
module pll_switch_seq #(
  parameter int SETTLE_CYC = 1200,
  parameter int MULT_MAX   = 32,
  localparam int MW = $clog2(MULT_MAX + 1),
  localparam int CW = $clog2(SETTLE_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          pll_lock,
  output logic          pll_pwr,
  output logic [MW-1:0] fb_mult,
  output logic [1:0]    div_code,
  output logic [2:0]    state_o,
  output logic          err_cfg,
  output logic          err_seq,
  output logic          sel_rc,
  output logic          sel_pll
);

  typedef enum logic [2:0] {
    S_OFF = 3'd0, S_CFG = 3'd1, S_SETTLE = 3'd2, S_LOCK = 3'd3, S_LIVE = 3'd4
  } st_t;

  st_t          st, st_n;
  logic [CW-1:0] cnt;
  logic          cnt_clr, seq_bad, pwr_n;
  logic          pll_q1, rc_q1;
  logic [1:0]    div_n;

  wire cfg_open = (st == S_OFF) || (st == S_CFG);
  wire mult_ok  = (wr_data >= 8'd1) && (wr_data <= 8'(MULT_MAX));
  wire div_ok   = (wr_data == 8'd2) || (wr_data == 8'd4) ||
                  (wr_data == 8'd8) || (wr_data == 8'd16);
  wire mult_acc = wr_en && (wr_addr == 2'd0) && mult_ok && cfg_open;
  wire div_acc  = wr_en && (wr_addr == 2'd1) && div_ok && cfg_open;
  wire cfg_bad  = wr_en && (wr_addr != 2'd2) && !mult_acc && !div_acc;

  wire cmd_wr   = wr_en && (wr_addr == 2'd2);
  wire cmd_many = cmd_wr && ($countones(wr_data[2:0]) > 1);
  wire any_cmd  = cmd_wr && (wr_data[2:0] != 3'b000);
  wire act      = cmd_wr && (wr_data[2:0] == 3'b001);
  wire con      = cmd_wr && (wr_data[2:0] == 3'b010);
  wire stp      = cmd_wr && (wr_data[2:0] == 3'b100);
  wire clr      = cmd_wr && wr_data[3];
  wire settled  = (cnt == CW'(SETTLE_CYC - 1));
  wire want_pll = (st == S_LIVE);

  assign state_o = st;

  always_comb begin
    case (wr_data[4:0])
      5'd2:    div_n = 2'd0;
      5'd4:    div_n = 2'd1;
      5'd8:    div_n = 2'd2;
      default: div_n = 2'd3;
    endcase
  end

  always_comb begin
    st_n    = st;
    cnt_clr = 1'b0;
    seq_bad = cmd_many;
    pwr_n   = pll_pwr;
    case (st)
      S_OFF: begin
        if (mult_acc || div_acc) st_n = S_CFG;
        if (act || con || stp) seq_bad = 1'b1;
      end
      S_CFG: begin
        if (act) begin
          st_n = S_SETTLE; cnt_clr = 1'b1; pwr_n = 1'b1;
        end else if (con || stp) seq_bad = 1'b1;
      end
      S_SETTLE: begin
        if (act) cnt_clr = 1'b1;
        else if (stp) begin
          st_n = S_CFG; pwr_n = 1'b0;
        end else if (con) seq_bad = 1'b1;
        else if (settled && pll_lock) st_n = S_LOCK;
      end
      S_LOCK, S_LIVE: begin
        if (!pll_lock) begin
          st_n = S_SETTLE; cnt_clr = 1'b1;
          if (any_cmd) seq_bad = 1'b1;
        end else if (st == S_LOCK) begin
          if (act) begin
            st_n = S_SETTLE; cnt_clr = 1'b1;
          end else if (stp) begin
            st_n = S_CFG; pwr_n = 1'b0;
          end else if (con) st_n = S_LIVE;
        end else begin
          if (stp) st_n = S_LOCK;
          else if (act || con) seq_bad = 1'b1;
        end
      end
      default: st_n = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_OFF;
      cnt      <= '0;
      pll_pwr  <= 1'b0;
      fb_mult  <= MW'(1);
      div_code <= 2'd0;
      err_cfg  <= 1'b0;
      err_seq  <= 1'b0;
    end else begin
      st      <= st_n;
      pll_pwr <= pwr_n;
      if (cnt_clr) cnt <= '0;
      else if (st == S_SETTLE && !settled) cnt <= cnt + 1'b1;
      if (mult_acc) fb_mult <= wr_data[MW-1:0];
      if (div_acc) div_code <= div_n;
      err_cfg <= cfg_bad ? 1'b1 : (clr ? 1'b0 : err_cfg);
      err_seq <= seq_bad ? 1'b1 : (clr ? 1'b0 : err_seq);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_q1  <= 1'b0;
      sel_pll <= 1'b0;
      rc_q1   <= 1'b1;
      sel_rc  <= 1'b1;
    end else begin
      pll_q1  <= want_pll & ~sel_rc;
      sel_pll <= pll_q1;
      rc_q1   <= ~want_pll & ~sel_pll;
      sel_rc  <= rc_q1;
    end
  end

  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_rc && sel_pll)); // R7
  AST_SETTLE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOCK && $past(st) == S_SETTLE) |-> ($past(settled) && $past(pll_lock))); // R5
  AST_LIVE_FROM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LIVE && $past(st) != S_LIVE) |-> ($past(st) == S_LOCK)); // R6
  AST_PWR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OFF || st == S_CFG) |-> !pll_pwr); // R4
  AST_LOSS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_LOCK || st == S_LIVE) && !pll_lock) |=> (st == S_SETTLE)); // R8
  AST_SEQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_seq && !clr) |=> err_seq); // R10
  AST_MULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_mult >= MW'(1)) && (fb_mult <= MW'(MULT_MAX))); // R2

endmodule

// File: tb/pll_switch_seq_bench.sv
`timescale 1ns/1ps
module pll_switch_seq_bench;
  localparam int SC = 1200;

  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, pll_lock = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pll_pwr, err_cfg, err_seq, sel_rc, sel_pll;
  logic [5:0] fb_mult;
  logic [1:0] div_code;
  logic [2:0] state_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pll_switch_seq #(.SETTLE_CYC(SC), .MULT_MAX(32)) u_pll_switch_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pll_lock(pll_lock), .pll_pwr(pll_pwr), .fb_mult(fb_mult), .div_code(div_code),
    .state_o(state_o), .err_cfg(err_cfg), .err_seq(err_seq), .sel_rc(sel_rc),
    .sel_pll(sel_pll));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic bit mult_legal(int d);
    return d >= 1 && d <= 32;
  endfunction

  function automatic int div_enc(int d);
    case (d)
      2: return 0;
      4: return 1;
      8: return 2;
      16: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic settle_full(string req);
    step(SC - 1);
    chk({req, " still settling"}, state_o, 2);
    step(1);
    chk({req, " locked"}, state_o, 3);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int em, ed;
    bit ee, cfgd;
    void'($urandom(32'h5eed));
    step(5);
    rst_n = 1'b1;
    step(1);
    // R1 reset values
    chk("R1 state", state_o, 0);
    chk("R1 pwr", pll_pwr, 0);
    chk("R1 sel_rc", sel_rc, 1);
    chk("R1 sel_pll", sel_pll, 0);
    chk("R1 mult", fb_mult, 1);
    chk("R1 div", div_code, 0);
    chk("R1 errs", {err_cfg, err_seq}, 0);

    // R4 / R6 / R9 commands in off state
    wr(2, 8'h01);
    chk("R4 act in off state", state_o, 0);
    chk("R4 act in off err", err_seq, 1);
    chk("R4 act in off pwr", pll_pwr, 0);
    wr(2, 8'h08);
    chk("R10 clear", err_seq, 0);
    wr(2, 8'h02);
    chk("R6 con in off err", err_seq, 1);
    wr(2, 8'h0C);
    chk("R9 stop in off, clear loses to error", err_seq, 1);
    wr(2, 8'h08);

    // R2 / R3 directed extremes then random
    em = 1; ed = 0; ee = 0; cfgd = 0;
    wr(0, 8'd32);  chk("R2 mult 32", fb_mult, 32);
    wr(0, 8'd33);  chk("R2 mult 33 kept", fb_mult, 32); chk("R2 err", err_cfg, 1);
    wr(0, 8'd0);   chk("R2 mult 0 kept", fb_mult, 32);
    wr(1, 8'd16);  chk("R3 div16", div_code, 3);
    wr(1, 8'd6);   chk("R3 div6 kept", div_code, 3);
    wr(2, 8'h08);  chk("R10 clear cfg", err_cfg, 0);
    wr(3, 8'd4);   chk("R11 addr3", err_cfg, 1);
    wr(2, 8'h08);
    em = 32; ed = 3; cfgd = 1;
    for (int i = 0; i < 60; i++) begin
      int a, d, c;
      a = $urandom_range(0, 1);
      d = ($urandom_range(0, 3) == 0) ? (1 << $urandom_range(0, 5)) : $urandom_range(0, 40);
      wr(2'(a), 8'(d));
      if (a == 0) begin
        if (mult_legal(d)) em = d; else ee = 1;
      end else begin
        c = div_enc(d);
        if (c >= 0) ed = c; else ee = 1;
      end
      chk("R2 random mult", fb_mult, em);
      chk("R3 random div", div_code, ed);
      chk("R2 R3 random err_cfg", err_cfg, int'(ee));
    end
    chk("R2 state configured", state_o, 1);
    wr(0, 8'd20); wr(1, 8'd4); wr(2, 8'h08);

    // R10 multiple command bits
    wr(2, 8'h03);
    chk("R10 multi state", state_o, 1);
    chk("R10 multi err", err_seq, 1);
    wr(2, 8'h08);

    // R4 / R5 activation with lock high
    pll_lock = 1'b1;
    wr(2, 8'h01);
    chk("R4 settling", state_o, 2);
    chk("R4 pwr", pll_pwr, 1);
    settle_full("R5");

    // R11 config rejected once running
    wr(0, 8'd5);
    chk("R11 mult kept", fb_mult, 20);
    chk("R11 err", err_cfg, 1);
    wr(2, 8'h08);

    // R4 restart on re-activation
    wr(2, 8'h01);
    chk("R4 reactivate", state_o, 2);
    step(SC / 2);
    wr(2, 8'h01);
    settle_full("R4 restart");

    // R6 / R7 connect and switch timing
    wr(2, 8'h02);
    chk("R6 connected", state_o, 4);
    step(2);
    chk("R7 rc off", sel_rc, 0);
    chk("R7 gap pll", sel_pll, 0);
    step(2);
    chk("R7 pll on", sel_pll, 1);
    wr(2, 8'h02);
    chk("R6 con in live err", err_seq, 1);
    chk("R6 stays live", state_o, 4);
    wr(2, 8'h08);

    // R9 release back to RC
    wr(2, 8'h04);
    chk("R9 release state", state_o, 3);
    step(2);
    chk("R9 pll off", sel_pll, 0);
    step(2);
    chk("R9 rc on", sel_rc, 1);

    // R8 lock loss while connected
    wr(2, 8'h02);
    step(4);
    chk("R8 pre pll", sel_pll, 1);
    pll_lock = 1'b0;
    step(1);
    chk("R8 to settling", state_o, 2);
    step(2);
    chk("R8 pll dropped", sel_pll, 0);
    step(2);
    chk("R8 rc back", sel_rc, 1);
    pll_lock = 1'b1;
    step(SC - 5);
    chk("R8 count restarted", state_o, 2);
    step(1);
    chk("R8 relocked", state_o, 3);

    // R9 stop in locked
    wr(2, 8'h04);
    chk("R9 stop state", state_o, 1);
    chk("R9 stop pwr", pll_pwr, 0);

    // R5 lock low holds settling
    pll_lock = 1'b0;
    wr(2, 8'h01);
    step(SC + 5);
    chk("R5 no lock stays", state_o, 2);
    pll_lock = 1'b1;
    step(1);
    chk("R5 lock arrives", state_o, 3);

    // R12 lock loss and connect in the same cycle
    @(negedge clk);
    pll_lock = 1'b0; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h02;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R12 state", state_o, 2);
    chk("R12 err", err_seq, 1);
    step(4);
    chk("R12 no pll", sel_pll, 0);
    wr(2, 8'h08);

    // R9 stop in settling
    wr(2, 8'h04);
    chk("R9 stop in settling", state_o, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule